// File: doc/BRIEF.md
# Supervisory Reset and Pushbutton Controller

This block produces the active-low system reset for a processor subsystem. Three things can request a reset: a supply monitor flag that reports the supply out of tolerance, a pushbutton wired onto the shared open-drain reset line, and a timeout request from a watchdog. The block pulls the reset line low through an output enable (`pin_drive_o`). It also watches the line's level through a synchronizer, so it can tell when an external switch pulls the line low.

Each reset ends with a hold window of a fixed number of clock cycles. If a new watchdog request arrives during that window, the window starts over. When supply returns, the block can wait for an oscillator start-up flag before starting the hold. A button press runs in four steps. First the block drives the line low for a debounce interval. It then lets go and waits a few cycles for the line to settle. If the line is still low, it waits for the button to be released. On release it drives a full hold pulse. A status output reports whether a reset cycle is in progress.

The line is modelled outside the block as `level = !(drive | button)`. The supply comparator and the oscillator are modelled as plain digital flags.

Top module: `reset_supervisor`

## Requirements
- R1: While `pwr_bad_i` is sampled high on a clock edge, `pin_drive_o` and `rst_active_o` are 1 from that edge on, whatever else is happening. This includes a running hold, a debounce, or a wait for button release.
- R2: Suppose `pwr_bad_i` is sampled low after being high, with `osc_stop_bkup_i` = 0 or `osc_ready_i` = 1. Then `pin_drive_o` stays 1 for exactly `HOLD_CYC` more cycles and then goes to 0.
- R3: Suppose `pwr_bad_i` falls while `osc_stop_bkup_i` = 1 and `osc_ready_i` = 0. Then `pin_drive_o` stays 1 until `osc_ready_i` is sampled 1. It then stays 1 for exactly `HOLD_CYC` further cycles.
- R4: While `arst_n` is low, `pin_drive_o` = 1 and `rst_active_o` = 1. After `arst_n` is released, the drive lasts `HOLD_CYC` cycles, counting the cycle in which the release happens.
- R5: In the idle state, a falling edge of the synchronized line level starts the debounce. The drive begins `SYNC_STAGES`+1 cycles after the line falls and lasts exactly `DEB_CYC` cycles.
- R6: After the debounce, the drive is released for a settle window of `SYNC_STAGES`+2 cycles, and `rst_active_o` stays 1. If the line is still low at the end of the window, the block waits with drive 0 and active 1. A rising edge then starts a `HOLD_CYC` drive `SYNC_STAGES`+1 cycles after the release. If the line is high at the end of the window, the block returns to idle with no hold pulse.
- R7: A `wdt_expire_i` pulse in idle, hold, debounce, settle or wait-for-release starts a hold of exactly `HOLD_CYC` cycles counted from that request. During a running hold, this means the window restarts.
- R8: Rising or falling line levels caused by the block's own drive never start a debounce. After any hold or debounce ends with no new request, `pin_drive_o` stays 0.
- R9: `rst_active_o` is 0 only in the idle state. Whenever `pin_drive_o` is 1, `rst_active_o` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; starts a power-on hold |
| pwr_bad_i | input | 1 | 1 while the supply is out of tolerance |
| osc_stop_bkup_i | input | 1 | 1 when the oscillator is stopped in backup, which adds a start-up wait |
| osc_ready_i | input | 1 | 1 once the oscillator has started |
| wdt_expire_i | input | 1 | Watchdog timeout request, one cycle per request |
| pin_level_i | input | 1 | Asynchronous level of the reset line |
| pin_drive_o | output | 1 | 1 = pull the reset line low |
| rst_active_o | output | 1 | 1 while any reset cycle is in progress |

## Verification
The checker runs on every cycle. It checks that a sampled supply fault always produces drive on the next cycle. It checks that a watchdog request always lands in the hold state, and that a hold never ends in fewer than `HOLD_CYC` cycles. It also checks that every debounce lasts exactly `DEB_CYC` cycles and can start only from idle, and that the wait-for-release state never drives the line. Other behaviour depends on how the line, the button and the requests interact over time, and only the bench scenarios show it. This includes the exact pulse widths after supply recovery, after the oscillator wait and after a button release. It also includes the difference between a short press and a held press, and the absence of self-triggered debounces once the line rises again.

// File: rtl/rsup_pkg.sv
`timescale 1ns/1ps
package rsup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PWRFAIL  = 3'd1,
        ST_OSCWAIT  = 3'd2,
        ST_HOLD     = 3'd3,
        ST_DEBOUNCE = 3'd4,
        ST_SETTLE   = 3'd5,
        ST_WAITREL  = 3'd6
    } rsup_state_e;

    function automatic int unsigned rsup_max3(input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rsup_pin_sync.sv
`timescale 1ns/1ps
module rsup_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_async_i,
    output logic lvl_o,
    output logic fall_o,
    output logic rise_o
);

    localparam int unsigned CHAIN_W = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
        logic               prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[CHAIN_W-2:0], pin_async_i};
        s_d.prev  = s_q.chain[CHAIN_W-1];
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_o  = s_q.chain[CHAIN_W-1];
    assign fall_o = s_q.prev & ~s_q.chain[CHAIN_W-1];
    assign rise_o = ~s_q.prev & s_q.chain[CHAIN_W-1];

endmodule

// File: rtl/rsup_timer.sv
`timescale 1ns/1ps
module rsup_timer #(
    parameter int unsigned     CNT_W   = 8,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d.cnt = load_val_i;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            t_q.cnt <= RST_VAL;
        end else begin
            t_q <= t_d;
        end
    end

    assign zero_o = (t_q.cnt == '0);

endmodule

// File: rtl/rsup_ctrl.sv
`timescale 1ns/1ps
module rsup_ctrl
    import rsup_pkg::*;
#(
    parameter int unsigned     CNT_W      = 8,
    parameter logic [CNT_W-1:0] HOLD_LD    = '0,
    parameter logic [CNT_W-1:0] DEB_LD     = '0,
    parameter logic [CNT_W-1:0] SETTLE_LD  = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             pwr_bad_i,
    input  logic             osc_stop_i,
    input  logic             osc_ready_i,
    input  logic             wdt_i,
    input  logic             lvl_i,
    input  logic             fall_i,
    input  logic             rise_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output rsup_state_e      state_o,
    output logic             drive_o,
    output logic             active_o
);

    typedef struct packed {
        rsup_state_e st;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d        = c_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        if (pwr_bad_i) begin
            c_d.st = ST_PWRFAIL;
        end else begin
            unique case (c_q.st)
                ST_PWRFAIL: begin
                    if (osc_stop_i && !osc_ready_i) begin
                        c_d.st = ST_OSCWAIT;
                    end else begin
                        c_d.st     = ST_HOLD;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = HOLD_LD;
                    end
                end
                ST_OSCWAIT: begin
                    if (osc_ready_i) begin
                        c_d.st     = ST_HOLD;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = HOLD_LD;
                    end
                end
                default: begin
                    if (wdt_i) begin
                        c_d.st     = ST_HOLD;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = HOLD_LD;
                    end else begin
                        unique case (c_q.st)
                            ST_HOLD: begin
                                if (tmr_zero_i) c_d.st = ST_IDLE;
                            end
                            ST_IDLE: begin
                                if (fall_i) begin
                                    c_d.st     = ST_DEBOUNCE;
                                    tmr_load_o = 1'b1;
                                    tmr_val_o  = DEB_LD;
                                end
                            end
                            ST_DEBOUNCE: begin
                                if (tmr_zero_i) begin
                                    c_d.st     = ST_SETTLE;
                                    tmr_load_o = 1'b1;
                                    tmr_val_o  = SETTLE_LD;
                                end
                            end
                            ST_SETTLE: begin
                                if (tmr_zero_i) begin
                                    c_d.st = lvl_i ? ST_IDLE : ST_WAITREL;
                                end
                            end
                            ST_WAITREL: begin
                                if (rise_i) begin
                                    c_d.st     = ST_HOLD;
                                    tmr_load_o = 1'b1;
                                    tmr_val_o  = HOLD_LD;
                                end
                            end
                            default: c_d.st = ST_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            c_q.st <= ST_HOLD;
        end else begin
            c_q <= c_d;
        end
    end

    assign state_o  = c_q.st;
    assign drive_o  = (c_q.st == ST_PWRFAIL) || (c_q.st == ST_OSCWAIT) ||
                      (c_q.st == ST_HOLD)    || (c_q.st == ST_DEBOUNCE);
    assign active_o = (c_q.st != ST_IDLE);

endmodule

// File: rtl/reset_supervisor.sv
`timescale 1ns/1ps
module reset_supervisor
    import rsup_pkg::*;
#(
    parameter int unsigned HOLD_CYC    = 1000,
    parameter int unsigned DEB_CYC     = 400,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pwr_bad_i,
    input  logic osc_stop_bkup_i,
    input  logic osc_ready_i,
    input  logic wdt_expire_i,
    input  logic pin_level_i,
    output logic pin_drive_o,
    output logic rst_active_o
);

    localparam int unsigned SETTLE_CYC = SYNC_STAGES + 2;
    localparam int unsigned MAX_CYC    = rsup_max3(HOLD_CYC, DEB_CYC, SETTLE_CYC);
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] DEB_LD    = CNT_W'(DEB_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

    logic             lvl, fall, rise;
    logic             tmr_zero, tmr_load;
    logic [CNT_W-1:0] tmr_val;
    rsup_state_e      ctrl_state;

    rsup_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .arst_n      (arst_n),
        .pin_async_i (pin_level_i),
        .lvl_o       (lvl),
        .fall_o      (fall),
        .rise_o      (rise)
    );

    rsup_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (HOLD_LD)
    ) u_timer (
        .clk        (clk),
        .arst_n     (arst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    rsup_ctrl #(
        .CNT_W     (CNT_W),
        .HOLD_LD   (HOLD_LD),
        .DEB_LD    (DEB_LD),
        .SETTLE_LD (SETTLE_LD)
    ) u_ctrl (
        .clk         (clk),
        .arst_n      (arst_n),
        .pwr_bad_i   (pwr_bad_i),
        .osc_stop_i  (osc_stop_bkup_i),
        .osc_ready_i (osc_ready_i),
        .wdt_i       (wdt_expire_i),
        .lvl_i       (lvl),
        .fall_i      (fall),
        .rise_i      (rise),
        .tmr_zero_i  (tmr_zero),
        .tmr_load_o  (tmr_load),
        .tmr_val_o   (tmr_val),
        .state_o     (ctrl_state),
        .drive_o     (pin_drive_o),
        .active_o    (rst_active_o)
    );

endmodule

// File: rtl/reset_supervisor_chk.sv
`timescale 1ns/1ps
module reset_supervisor_chk
    import rsup_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 1000,
    parameter int unsigned DEB_CYC  = 400
) (
    input logic        clk,
    input logic        arst_n,
    input logic        pwr_bad_i,
    input logic        wdt_expire_i,
    input logic        pin_drive_o,
    input logic        rst_active_o,
    input rsup_state_e state_i
);

    logic [31:0] hold_len_q, deb_len_q;
    rsup_state_e prev_st_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            hold_len_q <= '0;
            deb_len_q  <= '0;
            prev_st_q  <= ST_HOLD;
        end else begin
            hold_len_q <= (state_i == ST_HOLD) ?
                          ((hold_len_q == 32'hFFFF_FFFF) ? hold_len_q : hold_len_q + 1) : '0;
            deb_len_q  <= (state_i == ST_DEBOUNCE) ?
                          ((deb_len_q == 32'hFFFF_FFFF) ? deb_len_q : deb_len_q + 1) : '0;
            prev_st_q  <= state_i;
        end
    end

    AST_PWR_FORCES_DRIVE: assert property (@(posedge clk) disable iff (!arst_n)
        pwr_bad_i |=> (pin_drive_o && rst_active_o)); // R1

    AST_HOLD_MIN_LEN: assert property (@(posedge clk) disable iff (!arst_n)
        (state_i == ST_IDLE && hold_len_q != 0) |-> (hold_len_q >= HOLD_CYC)); // R2

    AST_DEB_EXACT_LEN: assert property (@(posedge clk) disable iff (!arst_n)
        (state_i == ST_SETTLE && deb_len_q != 0) |-> (deb_len_q == DEB_CYC)); // R5

    AST_WAITREL_QUIET: assert property (@(posedge clk) disable iff (!arst_n)
        (state_i == ST_WAITREL) |-> (!pin_drive_o && rst_active_o)); // R6

    AST_WDT_TO_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        (wdt_expire_i && !pwr_bad_i && state_i != ST_PWRFAIL && state_i != ST_OSCWAIT)
        |=> (state_i == ST_HOLD)); // R7

    AST_DEB_FROM_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
        (state_i == ST_DEBOUNCE && prev_st_q != ST_DEBOUNCE) |-> (prev_st_q == ST_IDLE)); // R8

    AST_DRIVE_ACTIVE: assert property (@(posedge clk) disable iff (!arst_n)
        pin_drive_o |-> rst_active_o); // R9

endmodule

bind reset_supervisor reset_supervisor_chk #(
    .HOLD_CYC (HOLD_CYC),
    .DEB_CYC  (DEB_CYC)
) u_chk (
    .clk          (clk),
    .arst_n       (arst_n),
    .pwr_bad_i    (pwr_bad_i),
    .wdt_expire_i (wdt_expire_i),
    .pin_drive_o  (pin_drive_o),
    .rst_active_o (rst_active_o),
    .state_i      (ctrl_state)
);

// File: tb/reset_supervisor_bench.sv
`timescale 1ns/1ps
module reset_supervisor_bench;

    localparam int HOLD = 20;
    localparam int DEB  = 12;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic arst_n = 1'b1;
    logic pwr_bad = 1'b0, osc_stop = 1'b0, osc_ready = 1'b1, wdt = 1'b0, btn = 1'b0;
    logic drive, active, pin;

    assign pin = ~(drive | btn);

    always #5 clk = ~clk;

    reset_supervisor #(
        .HOLD_CYC    (HOLD),
        .DEB_CYC     (DEB),
        .SYNC_STAGES (SYNC)
    ) u_reset_supervisor (
        .clk             (clk),
        .arst_n          (arst_n),
        .pwr_bad_i       (pwr_bad),
        .osc_stop_bkup_i (osc_stop),
        .osc_ready_i     (osc_ready),
        .wdt_expire_i    (wdt),
        .pin_level_i     (pin),
        .pin_drive_o     (drive),
        .rst_active_o    (active)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model of the requirements for the random phase (no button)
    // states: 0 idle, 1 supply fault, 2 oscillator wait, 3 hold
    bit m_en = 1'b0;
    int m_st = 0;
    int m_rem = 0;

    always @(posedge clk) begin
        if (m_en) begin
            if (pwr_bad) m_st <= 1;
            else begin
                case (m_st)
                    1: if (osc_stop && !osc_ready) m_st <= 2;
                       else begin m_st <= 3; m_rem <= HOLD - 1; end
                    2: if (osc_ready) begin m_st <= 3; m_rem <= HOLD - 1; end
                    3: if (wdt) m_rem <= HOLD - 1;
                       else if (m_rem == 0) m_st <= 0;
                       else m_rem <= m_rem - 1;
                    default: if (wdt) begin m_st <= 3; m_rem <= HOLD - 1; end
                endcase
            end
        end
    end

    function automatic int exp_drive(input int st);
        return (st != 0) ? 1 : 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(output int w);
        w = 0;
        while (drive && w < 10000) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic wait_rise(output int d);
        d = 0;
        while (!drive && d < 1000) begin
            d++;
            @(negedge clk);
        end
    endtask

    task automatic quiet_window(input int n, input string tag);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            if (drive) seen++;
            @(negedge clk);
        end
        chk(seen == 0 && active == 1'b0, tag, seen, 0);
    endtask

    initial begin
        int w, d, bad;
        void'($urandom(32'h5EED_1234));
        #1 arst_n = 1'b0;
        step(3);
        chk(drive == 1'b1 && active == 1'b1, "R4 reset state drive/active", {drive, active}, 3);
        arst_n = 1'b1;
        measure(w);
        chk(w == HOLD, "R4 power-on hold width", w, HOLD);
        chk(active == 1'b0, "R9 active clears in idle", active, 0);
        quiet_window(40, "R8 no self-trigger after power-on hold");

        // supply fault without oscillator wait
        pwr_bad = 1'b1;
        step(1);
        chk(drive == 1'b1, "R1 drive one cycle after fault", drive, 1);
        step(4);
        pwr_bad = 1'b0;
        step(1);
        measure(w);
        chk(w == HOLD, "R2 hold after supply recovers", w, HOLD);
        quiet_window(30, "R8 idle after supply hold");

        // supply fault with oscillator start-up wait
        osc_stop = 1'b1; osc_ready = 1'b0; pwr_bad = 1'b1;
        step(3);
        pwr_bad = 1'b0;
        step(25);
        chk(drive == 1'b1 && active == 1'b1, "R3 drive held while oscillator not ready", drive, 1);
        osc_ready = 1'b1;
        step(1);
        measure(w);
        chk(w == HOLD, "R3 hold after oscillator ready", w, HOLD);
        osc_stop = 1'b0;
        quiet_window(30, "R8 idle after oscillator hold");

        // watchdog request in idle
        wdt = 1'b1;
        step(1);
        wdt = 1'b0;
        measure(w);
        chk(w == HOLD, "R7 watchdog hold width", w, HOLD);
        step(10);

        // long press
        btn = 1'b1;
        wait_rise(d);
        chk(d == SYNC + 1, "R5 debounce start latency", d, SYNC + 1);
        measure(w);
        chk(w == DEB, "R5 debounce width", w, DEB);
        bad = 0;
        for (int i = 0; i < 25; i++) begin
            if (drive != 1'b0 || active != 1'b1) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R6 settle and wait-for-release keep drive off, active on", bad, 0);
        btn = 1'b0;
        wait_rise(d);
        chk(d == SYNC + 1, "R6 hold start after release", d, SYNC + 1);
        measure(w);
        chk(w == HOLD, "R6 hold width after release", w, HOLD);
        quiet_window(40, "R8 no self-trigger after press hold");

        // short press: released during debounce
        btn = 1'b1;
        step(SYNC + 1);
        btn = 1'b0;
        measure(w);
        chk(w == DEB, "R5 short press debounce width", w, DEB);
        quiet_window(40, "R6 short press returns to idle without hold");

        // watchdog during debounce
        btn = 1'b1;
        wait_rise(d);
        step(2);
        wdt = 1'b1; btn = 1'b0;
        step(1);
        wdt = 1'b0;
        measure(w);
        chk(w == HOLD, "R7 watchdog during debounce gives full hold", w, HOLD);
        quiet_window(30, "R8 idle after watchdog over debounce");

        // supply fault while waiting for release
        btn = 1'b1;
        wait_rise(d);
        measure(w);
        step(8);
        pwr_bad = 1'b1;
        step(1);
        chk(drive == 1'b1, "R1 fault overrides wait-for-release", drive, 1);
        btn = 1'b0;
        step(3);
        pwr_bad = 1'b0;
        step(1);
        measure(w);
        chk(w == HOLD, "R2 hold after fault over button", w, HOLD);
        step(30);

        // constrained random phase against the reference model
        begin
            int burst;
            burst = 0;
            m_st = 0; m_rem = 0; m_en = 1'b1;
            for (int c = 0; c < 4000; c++) begin
                chk(drive == exp_drive(m_st)[0] && active == exp_drive(m_st)[0],
                    "R1/R2/R3/R7/R8/R9 random vs model", {drive, active}, exp_drive(m_st) * 3);
                if (burst > 0) begin
                    burst--;
                    pwr_bad = 1'b1;
                end else if ($urandom % 150 == 0) begin
                    burst = $urandom % 6;
                    pwr_bad = 1'b1;
                    osc_stop = 1'($urandom % 2);
                end else begin
                    pwr_bad = 1'b0;
                end
                osc_ready = ($urandom % 8) != 0;
                wdt = ($urandom % 30) == 0;
                step(1);
            end
            m_en = 1'b0;
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule